// File: doc/BRIEF.md
# Chip-Select Bus Sizing Controller

This block connects a 32-bit internal bus master to a 16-bit external memory bus. It maps an external address window onto four chip-select regions. Each region has its own data width, 8 or 16 bits, held in a 16-bit sizing register. An internal request of byte, halfword or word size becomes one or more external bus cycles. Each cycle has a base length plus a wait-state count. Before the master receives its single completion pulse, the block steers read bytes into their place in the internal word and moves write bytes onto the external lanes.

The master presents a request for one clock while the block is idle. The block then takes the region, its width, the wait count and the timing mode from that clock and keeps them until the access ends. Software programs the sizing register once after reset through a whole-word write port, and the register image can always be read back.

Top module: `csb_ctrl`

## Requirements
- R1: After reset the sizing register reads 0x5555 (all four regions 16 bits wide), no chip select or strobe is active and `req_ready` is low.
- R2: A write to the sizing register updates only bits 0, 2, 4 and 6, the width controls of regions 0, 1, 2 and 3 (0 = 8-bit, 1 = 16-bit). Bits 8, 10, 12 and 14 always read 1, all odd bits always read 0, and the full 16-bit image is always on `cfg_rdata`.
- R3: With the default limits, region 0 covers 0x100000–0x3FFFFF, region 1 0x400000–0x6FFFFF, region 2 0x700000–0x9FFFFF and region 3 0xA00000–0xBFFFFF. During an external cycle only `ext_cs` bit i of the addressed region is high, and at most one bit is high at any time.
- R4: A request outside 0x100000–0xBFFFFF runs no external cycle. It gets `req_ready` together with `req_err` in the clock after acceptance.
- R5: Each external cycle keeps its chip select, address and strobe for 3 + n clocks, where n is `wait_n`, or 2 + n clocks when `sep_mode` is 1.
- R6: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. A 16-bit region uses one cycle for a byte or halfword and two cycles (address, address + 2) for a word. An 8-bit region uses one cycle per byte at ascending addresses. `ext_be` is 11 for full 16-bit cycles. It is 01 or 10 for a byte on a 16-bit region, chosen by address bit 0, and 01 on 8-bit regions.
- R7: Read data for the byte at address A appears in `req_rdata` lane A[1:0]. A 16-bit region supplies the even byte on `ext_rdata[7:0]` and the odd byte on `ext_rdata[15:8]`, and an 8-bit region supplies the byte on `ext_rdata[7:0]`. Lanes the access does not cover read as zero.
- R8: Write byte at address A is taken from `req_wdata` lane A[1:0]. It drives `ext_wdata[7:0]` on 8-bit regions and lane A[0] of `ext_wdata` on 16-bit regions.
- R9: Completion is one `req_ready` pulse in the clock after the last external cycle, never together with a chip select. Requests arriving while busy are ignored.
- R10: `wait_n`, `sep_mode` and the region width are sampled when a request is accepted, and every external cycle of that access uses those values even if the inputs change meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the sizing register |
| cfg_wdata | input | 16 | Sizing register write value |
| cfg_rdata | output | 16 | Sizing register image |
| req_valid | input | 1 | Request presented (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 24 | Byte address, aligned to the size |
| req_wdata | input | 32 | Write data, byte lanes by address |
| req_rdata | output | 32 | Read data, valid with `req_ready` |
| req_ready | output | 1 | One-clock completion pulse |
| req_err | output | 1 | Address outside the window, with `req_ready` |
| wait_n | input | 2 | Wait states per external cycle |
| sep_mode | input | 1 | Shortened external cycle timing |
| ext_cs | output | 4 | Active-high chip selects |
| ext_addr | output | 24 | External byte address |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_be | output | 2 | External byte lane enables |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |

## Verification
The checks assume three things about the inputs. Requests are aligned to their size. The size code 3 is never used. `ext_rdata` is valid on the final clock of each read cycle. The stimulus draws its offsets only from aligned positions inside each region and issues only codes 0 to 2. It answers reads from a combinational memory model that follows the chip select and the programmed width, so read data is present during every clock of the cycle. Requests that arrive while busy, and changes to `wait_n` and `sep_mode`, are deliberately placed inside running accesses. The sizing register is written only while the block is idle.

// File: rtl/csb_pkg.sv
package csb_pkg;

    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 32;
    localparam int XDATA_W = 16;
    localparam int NUM_CS  = 4;
    localparam int WAIT_W  = 2;
    localparam int LEN_W   = 3;
    localparam int CFG_W   = 16;

    localparam logic [ADDR_W-1:0] WIN_LO    = 24'h100000;
    localparam logic [CFG_W-1:0]  CFG_FIXED = 16'h5500;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        acc_size_e         size;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Register image: fixed pattern with the width controls on even low bits
    function automatic logic [CFG_W-1:0] cfg_image(input logic [NUM_CS-1:0] w16);
        logic [CFG_W-1:0] v;
        v = CFG_FIXED;
        for (int i = 0; i < NUM_CS; i++) begin
            v[2*i] = w16[i];
        end
        return v;
    endfunction

    // Clocks per external cycle
    function automatic logic [LEN_W-1:0] cycle_len(input logic sep,
                                                   input logic [WAIT_W-1:0] n);
        return (sep ? LEN_W'(2) : LEN_W'(3)) + LEN_W'(n);
    endfunction

    // Number of external cycles minus one
    function automatic logic [1:0] extra_cycles(input acc_size_e sz,
                                                input logic port16);
        if (port16) begin
            return (sz == SZ_BYTE || sz == SZ_HALF) ? 2'd0 : 2'd1;
        end
        case (sz)
            SZ_BYTE: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/csb_cfg_reg.sv
module csb_cfg_reg
    import csb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [NUM_CS-1:0] width16
);

    logic [NUM_CS-1:0] w16_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            w16_q <= '1;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_CS; i++) begin
                w16_q[i] <= cfg_wdata[2*i];
            end
        end
    end

    assign width16   = w16_q;
    assign cfg_rdata = cfg_image(w16_q);

endmodule

// File: rtl/csb_decode.sv
module csb_decode
    import csb_pkg::*;
#(
    parameter logic [NUM_CS*ADDR_W-1:0] CS_LIMITS =
        {24'hBFFFFF, 24'h9FFFFF, 24'h6FFFFF, 24'h3FFFFF}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CS-1:0] sel,
    output logic              hit
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_rgn
        localparam logic [ADDR_W-1:0] HI = CS_LIMITS[i*ADDR_W +: ADDR_W];
        if (i == 0) begin : g_first
            assign sel[i] = (addr >= WIN_LO) && (addr <= HI);
        end else begin : g_rest
            localparam logic [ADDR_W-1:0] LO =
                CS_LIMITS[(i-1)*ADDR_W +: ADDR_W] + ADDR_W'(1);
            assign sel[i] = (addr >= LO) && (addr <= HI);
        end
    end

    assign hit = |sel;

endmodule

// File: rtl/csb_lane.sv
module csb_lane
    import csb_pkg::*;
(
    input  logic [1:0]         lane_addr,
    input  logic               port16,
    input  logic               byte_only,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [XDATA_W-1:0] ext_rdata,
    input  logic [DATA_W-1:0]  rbuf_in,
    output logic [1:0]         be,
    output logic [XDATA_W-1:0] xwdata,
    output logic [DATA_W-1:0]  rbuf_out
);

    always_comb begin
        rbuf_out = rbuf_in;
        xwdata   = '0;
        be       = '0;
        if (port16) begin
            be = byte_only ? (lane_addr[0] ? 2'b10 : 2'b01) : 2'b11;
            for (int l = 0; l < 2; l++) begin
                xwdata[8*l +: 8] = wdata[16*lane_addr[1] + 8*l +: 8];
                if (be[l]) begin
                    rbuf_out[16*lane_addr[1] + 8*l +: 8] = ext_rdata[8*l +: 8];
                end
            end
        end else begin
            be          = 2'b01;
            xwdata[7:0] = wdata[8*lane_addr +: 8];
            rbuf_out[8*lane_addr +: 8] = ext_rdata[7:0];
        end
    end

endmodule

// File: rtl/csb_seq.sv
module csb_seq
    import csb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  bus_req_t           req,
    input  logic               hit,
    input  logic [NUM_CS-1:0]  cs_sel,
    input  logic               port16,
    input  logic [WAIT_W-1:0]  wait_n,
    input  logic               sep_mode,
    input  logic [XDATA_W-1:0] ext_rdata,
    output logic [NUM_CS-1:0]  ext_cs,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic               ext_rd,
    output logic               ext_wr,
    output logic [1:0]         ext_be,
    output logic [XDATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0]  req_rdata,
    output logic               req_ready,
    output logic               req_err
);

    seq_state_e        state;
    bus_req_t          cur;
    logic              p16_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [1:0]        left_q;
    logic [NUM_CS-1:0] cs_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              err_q;

    logic [1:0]         be_w;
    logic [XDATA_W-1:0] xw_w;
    logic [DATA_W-1:0]  rmerge;
    logic               last_clk;
    logic               active;

    csb_lane u_lane (
        .lane_addr (cur.addr[1:0]),
        .port16    (p16_q),
        .byte_only (cur.size == SZ_BYTE),
        .wdata     (cur.wdata),
        .ext_rdata (ext_rdata),
        .rbuf_in   (rbuf_q),
        .be        (be_w),
        .xwdata    (xw_w),
        .rbuf_out  (rmerge)
    );

    assign last_clk = (cnt_q == len_q - LEN_W'(1));
    assign active   = (state == ST_BUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur    <= '0;
            p16_q  <= 1'b0;
            len_q  <= '0;
            cnt_q  <= '0;
            left_q <= '0;
            cs_q   <= '0;
            rbuf_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur    <= req;
                        p16_q  <= port16;
                        len_q  <= cycle_len(sep_mode, wait_n);
                        cnt_q  <= '0;
                        left_q <= extra_cycles(req.size, port16);
                        cs_q   <= cs_sel;
                        rbuf_q <= '0;
                        err_q  <= !hit;
                        state  <= hit ? ST_BUS : ST_DONE;
                    end
                end
                ST_BUS: begin
                    if (last_clk) begin
                        if (!cur.write) begin
                            rbuf_q <= rmerge;
                        end
                        cnt_q <= '0;
                        if (left_q == 2'd0) begin
                            state <= ST_DONE;
                        end else begin
                            left_q   <= left_q - 2'd1;
                            cur.addr <= cur.addr + (p16_q ? ADDR_W'(2) : ADDR_W'(1));
                        end
                    end else begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign ext_cs    = active ? cs_q : '0;
    assign ext_addr  = active ? cur.addr : '0;
    assign ext_rd    = active && !cur.write;
    assign ext_wr    = active && cur.write;
    assign ext_be    = active ? be_w : 2'b00;
    assign ext_wdata = (active && cur.write) ? xw_w : '0;
    assign req_ready = (state == ST_DONE);
    assign req_err   = req_ready && err_q;
    assign req_rdata = rbuf_q;

endmodule

// File: rtl/csb_ctrl.sv
module csb_ctrl
    import csb_pkg::*;
#(
    parameter logic [NUM_CS*ADDR_W-1:0] CS_LIMITS =
        {24'hBFFFFF, 24'h9FFFFF, 24'h6FFFFF, 24'h3FFFFF}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [DATA_W-1:0]  req_rdata,
    output logic               req_ready,
    output logic               req_err,
    input  logic [WAIT_W-1:0]  wait_n,
    input  logic               sep_mode,
    output logic [NUM_CS-1:0]  ext_cs,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic               ext_rd,
    output logic               ext_wr,
    output logic [1:0]         ext_be,
    output logic [XDATA_W-1:0] ext_wdata,
    input  logic [XDATA_W-1:0] ext_rdata
);

    logic [NUM_CS-1:0] width16;
    logic [NUM_CS-1:0] sel;
    logic              hit;
    bus_req_t          req;

    assign req = '{addr: req_addr, size: acc_size_e'(req_size),
                   write: req_write, wdata: req_wdata};

    csb_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .width16   (width16)
    );

    csb_decode #(.CS_LIMITS(CS_LIMITS)) u_dec (
        .addr (req_addr),
        .sel  (sel),
        .hit  (hit)
    );

    csb_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .hit       (hit),
        .cs_sel    (sel),
        .port16    (|(sel & width16)),
        .wait_n    (wait_n),
        .sep_mode  (sep_mode),
        .ext_rdata (ext_rdata),
        .ext_cs    (ext_cs),
        .ext_addr  (ext_addr),
        .ext_rd    (ext_rd),
        .ext_wr    (ext_wr),
        .ext_be    (ext_be),
        .ext_wdata (ext_wdata),
        .req_rdata (req_rdata),
        .req_ready (req_ready),
        .req_err   (req_err)
    );

endmodule

// File: rtl/csb_ctrl_chk.sv
module csb_ctrl_chk
    import csb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic [NUM_CS-1:0] ext_cs,
    input logic              ext_rd,
    input logic              ext_wr,
    input logic              req_ready,
    input logic              req_err
);

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ext_cs));

    // R2
    cfg_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[15:8] == 8'h55) && ((cfg_rdata & 16'h00AA) == 16'h0000));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R9
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ext_cs == '0));

    // R4
    err_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> req_ready);

    // R6
    strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_rd || ext_wr) |-> ((ext_cs != '0) && !(ext_rd && ext_wr)));

    // R5
    min_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|ext_cs) |=> (|ext_cs));

endmodule

bind csb_ctrl csb_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .ext_cs    (ext_cs),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .req_ready (req_ready),
    .req_err   (req_err)
);

// File: tb/csb_ctrl_test.sv
`timescale 1ns/1ps
module csb_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;
    logic        req_ready;
    logic        req_err;
    logic [1:0]  wait_n = '0;
    logic        sep_mode = 1'b0;
    logic [3:0]  ext_cs;
    logic [23:0] ext_addr;
    logic        ext_rd;
    logic        ext_wr;
    logic [1:0]  ext_be;
    logic [15:0] ext_wdata;
    logic [15:0] ext_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [3:0] tb_w16 = 4'hF;

    always #2.5 clk = ~clk;

    csb_ctrl uut (.*);

    function automatic logic [7:0] mb(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // External memory model
    always_comb begin
        ext_rdata = 16'hDEAD;
        for (int i = 0; i < 4; i++) begin
            if (ext_cs[i]) begin
                if (tb_w16[i]) ext_rdata = {mb({ext_addr[23:1], 1'b1}), mb({ext_addr[23:1], 1'b0})};
                else           ext_rdata = {8'hEE, mb(ext_addr)};
            end
        end
    end

    function automatic int exp_region(input logic [23:0] a);
        if (a < 24'h100000 || a > 24'hBFFFFF) return -1;
        if (a <= 24'h3FFFFF) return 0;
        if (a <= 24'h6FFFFF) return 1;
        if (a <= 24'h9FFFFF) return 2;
        return 3;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int i = 0; i < 4; i++) tb_w16[i] = v[2*i];
        // R2: image with fixed bits and the four width controls
        chk(cfg_rdata == (16'h5500 | (v & 16'h0055)), "R2", "cfg readback",
            {16'h0, cfg_rdata}, {16'h0, 16'h5500 | (v & 16'h0055)});
    endtask

    logic [23:0] sa [8];
    logic [1:0]  sbe[8];
    logic [15:0] swd[8];
    logic [3:0]  scs[8];
    logic        swr[8];
    int          slen[8];

    task automatic run_txn(input logic [23:0] a, input int sz, input bit wr,
                           input int wt, input bit sep, input bit noise);
        int rg, n, len, nsub, nready, ridx;
        bit p16, prev_act;
        logic [23:0] prev_addr;
        logic [31:0] wd, rd_got, rd_exp;
        bit err_got;
        rg  = exp_region(a);
        p16 = (rg >= 0) ? tb_w16[rg] : 1'b0;
        len = (sep ? 2 : 3) + wt;
        n   = (rg < 0) ? 0 : (p16 ? ((sz == 4) ? 2 : 1) : sz);
        wd  = {8'hA0 ^ a[7:0], 8'hB1, 8'hC2 ^ a[15:8], 8'hD3 ^ a[7:0]};
        nsub = 0; nready = 0; ridx = -1; prev_act = 0; prev_addr = '0;
        rd_got = '0; err_got = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        req_size = (sz == 1) ? 2'd0 : (sz == 2) ? 2'd1 : 2'd2;
        wait_n = 2'(wt); sep_mode = sep;
        for (int s = 0; s < 60; s++) begin
            @(negedge clk);
            if (ext_cs != 4'h0) begin
                if (!prev_act || ext_addr != prev_addr) begin
                    if (nsub < 8) begin
                        sa[nsub] = ext_addr; sbe[nsub] = ext_be; swd[nsub] = ext_wdata;
                        scs[nsub] = ext_cs; swr[nsub] = ext_wr && !ext_rd; slen[nsub] = 1;
                    end
                    nsub++;
                end else if (nsub <= 8) begin
                    slen[nsub-1]++;
                end
            end
            prev_act = (ext_cs != 4'h0);
            prev_addr = ext_addr;
            if (req_ready) begin
                nready++;
                if (ridx < 0) begin ridx = s; rd_got = req_rdata; err_got = req_err; end
            end
            if (s == 0) req_valid = 1'b0;
            if (noise && s == 1) begin
                req_valid = 1'b1; req_addr = 24'h500010; req_write = !wr;
                wait_n = ~wait_n; sep_mode = ~sep_mode;
            end
            if (noise && s == 2) req_valid = 1'b0;
            if (ridx >= 0 && s >= ridx + 3) break;
        end
        // R5 / R4: completion timing
        chk(ridx == n * len, (rg < 0) ? "R4" : "R5", "ready cycle", 32'(ridx), 32'(n * len));
        // R9
        chk(nready == 1, "R9", "ready pulses", 32'(nready), 32'd1);
        // R4
        chk(err_got == (rg < 0), "R4", "error flag", {31'h0, err_got}, {31'h0, rg < 0});
        // R6
        chk(nsub == n, "R6", "sub-cycle count", 32'(nsub), 32'(n));
        for (int k = 0; k < n && k < nsub && k < 8; k++) begin
            logic [23:0] ea;
            logic [1:0]  eb;
            logic [15:0] ew, m;
            if (p16) begin
                ea = (sz == 1) ? a : a + 24'(2 * k);
                eb = (sz == 1) ? (a[0] ? 2'b10 : 2'b01) : 2'b11;
                ew = {wd[8*(2*ea[1]+1) +: 8], wd[8*(2*ea[1]) +: 8]};
            end else begin
                ea = a + 24'(k);
                eb = 2'b01;
                ew = {8'h00, wd[8*ea[1:0] +: 8]};
            end
            chk(sa[k] == ea, "R6", "sub address", {8'h0, sa[k]}, {8'h0, ea});
            chk(sbe[k] == eb, "R6", "byte enables", {30'h0, sbe[k]}, {30'h0, eb});
            // R5 and R10: every sub-cycle keeps the length sampled at acceptance
            chk(slen[k] == len, noise ? "R10" : "R5", "cycle length", 32'(slen[k]), 32'(len));
            chk(scs[k] == 4'(1 << rg), "R3", "chip select", {28'h0, scs[k]}, 32'(1 << rg));
            chk(swr[k] == wr, "R6", "strobe direction", {31'h0, swr[k]}, {31'h0, wr});
            if (wr) begin
                m = {eb[1] ? 8'hFF : 8'h00, eb[0] ? 8'hFF : 8'h00};
                chk((swd[k] & m) == (ew & m), "R8", "write lanes",
                    {16'h0, swd[k] & m}, {16'h0, ew & m});
            end
        end
        if (!wr && rg >= 0) begin
            rd_exp = '0;
            for (int i = 0; i < sz; i++) begin
                logic [23:0] ba;
                ba = a + 24'(i);
                rd_exp[8*ba[1:0] +: 8] = mb(ba);
            end
            chk(rd_got == rd_exp, "R7", "read data", rd_got, rd_exp);
        end
    endtask

    initial begin
        logic [23:0] bases [4];
        logic [15:0] cfgs [2];
        bases[0] = 24'h100000; bases[1] = 24'h400000;
        bases[2] = 24'h700000; bases[3] = 24'hA00000;
        cfgs[0] = 16'hAA05; cfgs[1] = 16'h5550;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(cfg_rdata == 16'h5555, "R1", "reset image", {16'h0, cfg_rdata}, 32'h5555);
        chk(ext_cs == 4'h0 && !ext_rd && !ext_wr, "R1", "bus idle",
            {28'h0, ext_cs}, 32'h0);
        chk(req_ready == 1'b0, "R1", "ready low", {31'h0, req_ready}, 32'h0);
        // R2: reserved bits ignore writes
        write_cfg(16'hFFFF);
        write_cfg(16'h0000);
        write_cfg(16'hAAAA);
        // R3 / R4 boundaries with all regions 8-bit
        run_txn(24'h0FFFFC, 4, 0, 1, 0, 0);
        run_txn(24'hC00000, 2, 1, 0, 1, 0);
        run_txn(24'h100000, 1, 0, 0, 0, 0);
        run_txn(24'h3FFFFF, 1, 0, 0, 1, 0);
        run_txn(24'h400000, 1, 1, 2, 0, 0);
        run_txn(24'h6FFFFF, 1, 0, 0, 0, 0);
        run_txn(24'h700000, 1, 0, 3, 1, 0);
        run_txn(24'h9FFFFF, 1, 1, 0, 0, 0);
        run_txn(24'hA00000, 1, 0, 1, 0, 0);
        run_txn(24'hBFFFFF, 1, 0, 0, 0, 0);
        for (int c = 0; c < 2; c++) begin
            write_cfg(cfgs[c]);
            for (int r = 0; r < 4; r++)
                for (int szi = 0; szi < 3; szi++)
                    for (int off = 0; off < 4; off += (1 << szi))
                        for (int wr = 0; wr < 2; wr++)
                            for (int wt = 0; wt < 4; wt++)
                                for (int sp = 0; sp < 2; sp++)
                                    run_txn(bases[r] + 24'h000124 + 24'(off), 1 << szi,
                                            wr[0], wt, sp[0], wt[0]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule